// File: doc/BRIEF.md
# USB Full-Speed Transmit Serializer

This block turns a byte stream from on-chip logic into a full-speed USB line signal. Each packet it sends opens with the sync field, carries the bytes least significant bit first, can close with a CRC it computes itself, and ends with an end-of-packet sequence. It inserts stuffed bits, encodes the line as NRZI, and drives the DP/DM pins with an output enable that is high only while a packet is on the wire.

The producer offers bytes on a valid/ready interface. Each byte carries a start marker and a last marker, and the first byte of a packet also carries two flags: append a CRC, and pick the 5-bit token CRC instead of the 16-bit data CRC. One bit time passes for each cycle in which the 12 MHz bit enable is high. That enable is derived from the 48 MHz system clock, which clocks the whole block. The producer must offer the next byte whenever it is asked for one. If no byte is offered, the packet is cut short and closed at once.

Top module: `usb_fs_tx_serializer`

## Requirements
- R1: While reset is held and after it is released, `oe` is 0, the line rests at J (`dp`=1, `dm`=0) and `in_ready` is 0 in every cycle where `bit_en` is 0.
- R2: Every packet begins with the sync field, the byte 0x80 sent LSB first, which appears on the line as K J K J K J K K.
- R3: Bytes go out LSB first and are NRZI-encoded: a 0 changes the line between J (`dp`=1,`dm`=0) and K (`dp`=0,`dm`=1), and a 1 keeps it. The line is J before the sync field.
- R4: When CRC is enabled without the CRC-5 flag, a CRC-16 is sent after the last byte. It uses the polynomial x^16+x^15+x^2+1, starts from all ones, covers every byte except the first, and is sent inverted, highest-order bit first. A packet of one byte therefore ends in sixteen 0 bits.
- R5: When CRC is enabled with the CRC-5 flag, only the three low bits of the last byte are sent. They are followed by the inverted CRC-5 (polynomial x^5+x^2+1, all-ones start) computed over every bit after the first byte.
- R6: With CRC disabled, the last byte is followed directly by the end of packet.
- R7: After six consecutive 1 bits, a 0 bit is inserted. This applies in data and CRC alike, and also when the run ends on the final bit before the end of packet.
- R8: A packet ends with two bit times of SE0 (`dp`=`dm`=0), then one bit time of J, after which `oe` returns to 0 with the line at J.
- R9: `in_ready` is high only in cycles with `bit_en` high, never while a stuffed bit is being inserted, and in idle only for a byte that carries the start marker. A byte offered in idle without the start marker is not taken and starts nothing.
- R10: `dp`, `dm` and `oe` change only in the cycle after one in which `bit_en` was high. Each such change is one bit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | 12 MHz bit-time enable, one clock wide |
| in_data | input | 8 | Packet byte |
| in_valid | input | 1 | Byte offered |
| in_first | input | 1 | Byte is the first of a packet |
| in_last | input | 1 | Byte is the last of a packet |
| in_crc_en | input | 1 | Append a CRC (read with the first byte) |
| in_crc5 | input | 1 | Use CRC-5 token format (read with the first byte) |
| in_ready | output | 1 | Byte is taken at this clock edge |
| dp | output | 1 | D+ drive level |
| dm | output | 1 | D- drive level |
| oe | output | 1 | Line driver enable |

## Verification
A bad count in the run-length counter or the bit counter shows up on the very next bit time. The pattern on DP/DM then drifts from the expected NRZI pattern, because a stuffed bit lands in the wrong place or a byte boundary slips. A corrupted CRC register stays invisible until the CRC field goes out, and there the CRC bits differ. A lost or repeated handshake changes both the number of symbols between sync and SE0 and the number of bytes taken. The bench compares every bit time of every packet with a pattern it builds on its own. For the token case it uses a CRC value fixed in advance, not a computed one.

// File: rtl/usbtx_pkg.sv
// Shared types and constants for the full-speed transmit serializer.
package usbtx_pkg;
    // Operation applied to the line driver in one bit time.
    typedef enum logic [1:0] {
        LN_IDLE = 2'd0,
        LN_BIT  = 2'd1,
        LN_SE0  = 2'd2,
        LN_J    = 2'd3
    } line_op_t;

    // Phases of one packet.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SYNC = 3'd1,
        ST_DATA = 3'd2,
        ST_CRC  = 3'd3,
        ST_TAIL = 3'd4,
        ST_SE0A = 3'd5,
        ST_SE0B = 3'd6,
        ST_JEND = 3'd7
    } tx_state_t;

    localparam logic [7:0]  SYNC_PATTERN = 8'h80;
    localparam logic [15:0] POLY16       = 16'h8005;
    localparam logic [4:0]  POLY5        = 5'h05;
endpackage

// File: rtl/usbtx_crc.sv
// Bit-serial CRC generator.
// Assumes: data bits arrive LSB first, one per feed pulse. The remainder is read
// out inverted, highest-order bit first, one bit per shift pulse.
module usbtx_crc #(
    parameter int         W    = 16,
    parameter logic [W-1:0] POLY = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic feed,
    input  logic din,
    input  logic shift,
    output logic crc_bit
);
    logic [W-1:0] rem;

    assign crc_bit = ~rem[W-1];

    // Update the remainder: preset, absorb a bit, or shift out.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            rem <= '1;
        end else if (feed) begin
            rem <= {rem[W-2:0], 1'b0} ^ ((din ^ rem[W-1]) ? POLY : '0);
        end else if (shift) begin
            rem <= {rem[W-2:0], 1'b1};
        end
    end
endmodule

// File: rtl/usbtx_line.sv
// Stuffer, NRZI encoder and DP/DM drive for one bit time per enable.
// Assumes: op is steady around each bit_en edge. When stuff_now is high
// during LN_BIT, a 0 goes out and the caller holds its source bit.
module usbtx_line
    import usbtx_pkg::*;
#(
    parameter int RUN = 6
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bit_en,
    input  line_op_t op,
    input  logic     din,
    output logic     stuff_now,
    output logic     run_near,
    output logic     dp,
    output logic     dm,
    output logic     oe
);
    localparam int RW = $clog2(RUN + 1);

    logic [RW-1:0] ones;
    logic          lvl;
    logic          bit_out;
    logic          lvl_nxt;

    assign stuff_now = (ones == RW'(RUN));
    assign run_near  = (ones == RW'(RUN - 1));

    // Pick the bit on the wire and its NRZI level.
    always_comb begin
        bit_out = stuff_now ? 1'b0 : din;
        lvl_nxt = bit_out ? lvl : ~lvl;
    end

    // Drive the pins and track the run of ones, once per bit time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones <= '0;
            lvl  <= 1'b1;
            dp   <= 1'b1;
            dm   <= 1'b0;
            oe   <= 1'b0;
        end else if (bit_en) begin
            case (op)
                LN_BIT: begin
                    lvl  <= lvl_nxt;
                    dp   <= lvl_nxt;
                    dm   <= ~lvl_nxt;
                    oe   <= 1'b1;
                    ones <= bit_out ? ones + 1'b1 : '0;
                end
                LN_SE0: begin
                    dp   <= 1'b0;
                    dm   <= 1'b0;
                    oe   <= 1'b1;
                    ones <= '0;
                end
                LN_J: begin
                    lvl  <= 1'b1;
                    dp   <= 1'b1;
                    dm   <= 1'b0;
                    oe   <= 1'b1;
                    ones <= '0;
                end
                default: begin
                    lvl  <= 1'b1;
                    dp   <= 1'b1;
                    dm   <= 1'b0;
                    oe   <= 1'b0;
                    ones <= '0;
                end
            endcase
        end
    end

    // R7
    stuff_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && op == LN_BIT && stuff_now) |=> (oe && dp != $past(dp)));
    // R8
    eop_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe) |-> ($past(dp) && !$past(dm)));
    // R10
    hold_between_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_en) |-> ($stable(dp) && $stable(dm) && $stable(oe)));
endmodule

// File: rtl/usb_fs_tx_serializer.sv
// Full-speed transmit serializer: sync, LSB-first bytes, optional CRC-16 or
// CRC-5, bit stuffing, NRZI and end of packet.
// Assumes: bit_en is a one-clock pulse every bit time. The producer offers the
// next byte when in_ready asks for it; a missing byte closes the packet.
module usb_fs_tx_serializer
    import usbtx_pkg::*;
#(
    parameter int STUFF_RUN = 6,
    parameter int BYTE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic              in_last,
    input  logic              in_crc_en,
    input  logic              in_crc5,
    output logic              in_ready,
    output logic              dp,
    output logic              dm,
    output logic              oe
);
    localparam int CNT_W = 5;

    tx_state_t         state;
    logic [BYTE_W-1:0] sh, hold;
    logic [CNT_W-1:0]  cnt, byte_bits, crc_bits;
    logic              hold_last, cur_last, cur_first, crc_on, crc5;
    logic              stuff_now, run_near, src_bit, advance;
    logic              end_byte, end_crc, want_byte, tail_needed;
    logic              c16_bit, c5_bit, crc_feed, crc_shift;
    line_op_t          op;
    tx_state_t         finish_st;

    // Derive bit counts, the source bit and the handshake for this bit time.
    always_comb begin
        byte_bits   = (crc5 && crc_on && cur_last && !cur_first) ? CNT_W'(3) : CNT_W'(BYTE_W);
        crc_bits    = crc5 ? CNT_W'(5) : CNT_W'(16);
        src_bit     = (state == ST_CRC) ? (crc5 ? c5_bit : c16_bit) : sh[0];
        advance     = bit_en && !stuff_now;
        end_byte    = (cnt == byte_bits - 1'b1);
        end_crc     = (cnt == crc_bits - 1'b1);
        want_byte   = (state == ST_DATA) && end_byte && !cur_last;
        in_ready    = bit_en && (((state == ST_IDLE) && in_first) || (want_byte && !stuff_now));
        tail_needed = run_near && src_bit;
        finish_st   = tail_needed ? ST_TAIL : ST_SE0A;
        crc_feed    = advance && (state == ST_DATA) && !cur_first;
        crc_shift   = advance && (state == ST_CRC);
        case (state)
            ST_IDLE:          op = LN_IDLE;
            ST_SE0A, ST_SE0B: op = LN_SE0;
            ST_JEND:          op = LN_J;
            default:          op = LN_BIT;
        endcase
    end

    // Step the packet sequencer once per bit time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sh        <= '0;
            hold      <= '0;
            cnt       <= '0;
            hold_last <= 1'b0;
            cur_last  <= 1'b0;
            cur_first <= 1'b0;
            crc_on    <= 1'b0;
            crc5      <= 1'b0;
        end else if (bit_en) begin
            case (state)
                ST_IDLE: if (in_valid && in_first) begin
                    hold      <= in_data;
                    hold_last <= in_last;
                    crc_on    <= in_crc_en;
                    crc5      <= in_crc5;
                    sh        <= SYNC_PATTERN;
                    cnt       <= '0;
                    state     <= ST_SYNC;
                end
                ST_SYNC: begin
                    if (cnt == CNT_W'(BYTE_W - 1)) begin
                        sh        <= hold;
                        cnt       <= '0;
                        cur_last  <= hold_last;
                        cur_first <= 1'b1;
                        state     <= ST_DATA;
                    end else begin
                        sh  <= sh >> 1;
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: if (!stuff_now) begin
                    sh  <= sh >> 1;
                    cnt <= cnt + 1'b1;
                    if (end_byte) begin
                        cnt <= '0;
                        if (!cur_last) begin
                            if (in_valid) begin
                                sh        <= in_data;
                                cur_last  <= in_last;
                                cur_first <= 1'b0;
                            end else begin
                                state <= finish_st;
                            end
                        end else if (crc_on) begin
                            state <= ST_CRC;
                        end else begin
                            state <= finish_st;
                        end
                    end
                end
                ST_CRC: if (!stuff_now) begin
                    cnt <= cnt + 1'b1;
                    if (end_crc) state <= finish_st;
                end
                ST_TAIL: state <= ST_SE0A;
                ST_SE0A: state <= ST_SE0B;
                ST_SE0B: state <= ST_JEND;
                default: state <= ST_IDLE;
            endcase
        end
    end

    usbtx_crc #(.W(16), .POLY(POLY16)) i_crc16 (
        .clk(clk), .rst_n(rst_n), .init(state == ST_IDLE), .feed(crc_feed),
        .din(sh[0]), .shift(crc_shift), .crc_bit(c16_bit)
    );

    usbtx_crc #(.W(5), .POLY(POLY5)) i_crc5 (
        .clk(clk), .rst_n(rst_n), .init(state == ST_IDLE), .feed(crc_feed),
        .din(sh[0]), .shift(crc_shift), .crc_bit(c5_bit)
    );

    usbtx_line #(.RUN(STUFF_RUN)) i_line (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .op(op), .din(src_bit),
        .stuff_now(stuff_now), .run_near(run_near), .dp(dp), .dm(dm), .oe(oe)
    );

    // R9
    no_ready_in_stuff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !stuff_now);
    // R2
    sync_starts_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && state == ST_SYNC && cnt == '0) |=> (oe && !dp && dm));
endmodule

// File: tb/test_usb_fs_tx_serializer.sv
module test_usb_fs_tx_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_DIV    = 4;
    localparam int MAXS       = 512;

    logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0;
    logic [7:0] in_data = '0;
    logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_crc_en = 1'b0, in_crc5 = 1'b0;
    logic in_ready, dp, dm, oe;

    int n_checks = 0, n_fail = 0;
    int div = 0;
    logic en_q = 1'b0, rdy_q = 1'b0;

    logic [7:0] pkt [0:15];
    logic [7:0] epkt [0:15];
    logic [1:0] cap [0:MAXS-1];
    logic       cap_rdy [0:MAXS-1];
    logic [1:0] exp_sym [0:MAXS-1];
    logic       exp_stuff [0:MAXS-1];
    int cap_n = 0, exp_n = 0, acc_n = 0;
    logic seen = 1'b0, pkt_done = 1'b0, capture_on = 1'b0;

    usb_fs_tx_serializer i_usb_fs_tx_serializer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_data(in_data), .in_valid(in_valid),
        .in_first(in_first), .in_last(in_last), .in_crc_en(in_crc_en), .in_crc5(in_crc5),
        .in_ready(in_ready), .dp(dp), .dm(dm), .oe(oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bit enable: one clock in BIT_DIV, changed at the falling edge.
    always @(negedge clk) begin
        div    = (div + 1) % BIT_DIV;
        bit_en = (div == 0);
    end

    always @(posedge clk) begin
        en_q  <= bit_en;
        rdy_q <= in_ready;
    end

    // Capture one symbol per bit time while the driver is enabled.
    always @(negedge clk) begin
        if (en_q && capture_on) begin
            if (oe) begin
                if (cap_n < MAXS) begin
                    cap[cap_n]     = {dp, dm};
                    cap_rdy[cap_n] = rdy_q;
                end
                cap_n = cap_n + 1;
                seen  = 1'b1;
            end else if (seen) begin
                pkt_done = 1'b1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Offer n bytes of pkt through the handshake.
    task automatic drive(input int n, input bit crc_en, input bit c5);
        for (int i = 0; i < n; i++) begin
            bit taken = 1'b0;
            in_data = pkt[i]; in_valid = 1'b1; in_first = (i == 0); in_last = (i == n - 1);
            in_crc_en = crc_en; in_crc5 = c5;
            while (!taken) begin
                @(negedge clk); #1;
                if (in_ready) taken = 1'b1;
                @(posedge clk);
            end
            #1;
            acc_n++;
        end
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    endtask

    // Build the expected line from epkt: sync, LSB-first bits, CRC, stuffing, NRZI, EOP.
    task automatic build_expected(input int n, input bit crc_en, input bit c5);
        bit raw [0:MAXS-1];
        int rn = 0, ones = 0;
        logic [15:0] c16 = 16'hFFFF;
        logic [4:0]  c5r = 5'h1F;
        bit lvl = 1'b1;
        for (int k = 0; k < 8; k++) raw[rn++] = (k == 7);
        for (int i = 0; i < n; i++) begin
            int nb = (crc_en && c5 && i == n - 1 && i != 0) ? 3 : 8;
            for (int k = 0; k < nb; k++) begin
                bit b = epkt[i][k];
                raw[rn++] = b;
                if (i != 0) begin
                    c16 = {c16[14:0], 1'b0} ^ ((b ^ c16[15]) ? 16'h8005 : 16'h0);
                    c5r = {c5r[3:0], 1'b0} ^ ((b ^ c5r[4]) ? 5'h05 : 5'h0);
                end
            end
        end
        if (crc_en && !c5) for (int k = 15; k >= 0; k--) raw[rn++] = ~c16[k];
        if (crc_en && c5)  for (int k = 4; k >= 0; k--)  raw[rn++] = ~c5r[k];
        exp_n = 0;
        for (int j = 0; j < rn; j++) begin
            if (!raw[j]) lvl = ~lvl;
            exp_stuff[exp_n] = 1'b0;
            exp_sym[exp_n++] = lvl ? 2'b10 : 2'b01;
            ones = raw[j] ? ones + 1 : 0;
            if (ones == 6) begin
                lvl = ~lvl;
                exp_stuff[exp_n] = 1'b1;
                exp_sym[exp_n++] = lvl ? 2'b10 : 2'b01;
                ones = 0;
            end
        end
        exp_stuff[exp_n] = 1'b0; exp_sym[exp_n++] = 2'b00;
        exp_stuff[exp_n] = 1'b0; exp_sym[exp_n++] = 2'b00;
        exp_stuff[exp_n] = 1'b0; exp_sym[exp_n++] = 2'b10;
    endtask

    // Send one packet and compare it bit time by bit time.
    task automatic run_packet(input string req, input int n, input bit crc_en, input bit c5,
                              input int en, input bit ecrc, input bit ec5);
        int bad = -1, rdy_bad = 0;
        cap_n = 0; acc_n = 0; seen = 1'b0; pkt_done = 1'b0; capture_on = 1'b1;
        build_expected(en, ecrc, ec5);
        fork
            drive(n, crc_en, c5);
            wait (pkt_done);
        join
        capture_on = 1'b0;
        check(cap_n == exp_n, {req, " R10"}, "symbol count", cap_n, exp_n);
        for (int j = 0; j < exp_n && j < cap_n; j++) begin
            if (bad < 0 && cap[j] != exp_sym[j]) bad = j;
            if (exp_stuff[j] && cap_rdy[j]) rdy_bad++;
        end
        check(bad < 0, req, "first mismatching bit time", bad, -1);
        if (bad >= 0) $display("  at %0d line %b expected %b", bad, cap[bad], exp_sym[bad]);
        check(acc_n == n, req, "bytes taken", acc_n, n);
        check(rdy_bad == 0, "R9", "ready during stuffed bit", rdy_bad, 0);
        @(negedge clk);
        check(!oe && dp && !dm, "R8", "idle J after EOP (oe,dp,dm)", {oe, dp, dm}, 3'b010);
    endtask

    task automatic test_reset();
        repeat (6) @(negedge clk);
        check(!oe && dp && !dm, "R1", "reset line (oe,dp,dm)", {oe, dp, dm}, 3'b010);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(!oe && dp && !dm, "R1", "idle line after reset", {oe, dp, dm}, 3'b010);
        while (bit_en) @(negedge clk);
        #1;
        check(!in_ready, "R1", "ready with bit_en low", in_ready, 0);
    endtask

    task automatic test_ignore_unmarked();
        int rdy_seen = 0;
        cap_n = 0; seen = 1'b0; capture_on = 1'b1;
        in_data = 8'hD2; in_valid = 1'b1; in_first = 1'b0; in_last = 1'b1;
        repeat (40) begin
            @(negedge clk); #1;
            if (in_ready) rdy_seen++;
        end
        in_valid = 1'b0; in_last = 1'b0;
        repeat (8) @(negedge clk);
        capture_on = 1'b0;
        check(rdy_seen == 0, "R9", "ready for byte without start", rdy_seen, 0);
        check(cap_n == 0 && !oe, "R9", "symbols sent for unmarked byte", cap_n, 0);
    endtask

    // Handshake packet, no CRC (R2 R3 R6).
    task automatic test_handshake();
        pkt[0] = 8'hD2; epkt[0] = 8'hD2;
        run_packet("R2 R3 R6", 1, 1'b0, 1'b0, 1, 1'b0, 1'b0);
    endtask

    // Data packet with CRC-16.
    task automatic test_data_crc16();
        pkt[0] = 8'hC3; pkt[1] = 8'h01; pkt[2] = 8'h02; pkt[3] = 8'h03; pkt[4] = 8'h04;
        for (int i = 0; i < 5; i++) epkt[i] = pkt[i];
        run_packet("R4", 5, 1'b1, 1'b0, 5, 1'b1, 1'b0);
    endtask

    // Zero-length data packet: CRC field is sixteen zeros.
    task automatic test_zero_length();
        pkt[0] = 8'h4B; epkt[0] = 8'h4B;
        run_packet("R4 zero-length", 1, 1'b1, 1'b0, 1, 1'b0, 1'b0);
        exp_n = 0;
    endtask

    task automatic test_zero_length_fixed();
        pkt[0] = 8'h4B; epkt[0] = 8'h4B; epkt[1] = 8'h00; epkt[2] = 8'h00;
        run_packet("R4 zero-length", 1, 1'b1, 1'b0, 3, 1'b0, 1'b0);
    endtask

    // Token, address 0 endpoint 0: known CRC-5 gives last byte 0x10.
    task automatic test_token_crc5();
        pkt[0] = 8'h2D; pkt[1] = 8'h00; pkt[2] = 8'h00;
        epkt[0] = 8'h2D; epkt[1] = 8'h00; epkt[2] = 8'h10;
        run_packet("R5", 3, 1'b1, 1'b1, 3, 1'b0, 1'b0);
    endtask

    // All-ones payload: heavy stuffing.
    task automatic test_stuffing();
        pkt[0] = 8'h4B; pkt[1] = 8'hFF; pkt[2] = 8'hFF; pkt[3] = 8'hFF;
        for (int i = 0; i < 4; i++) epkt[i] = pkt[i];
        run_packet("R7", 4, 1'b1, 1'b0, 4, 1'b1, 1'b0);
    endtask

    // Run of six ones at the very end: stuffed bit before EOP.
    task automatic test_tail_stuff();
        pkt[0] = 8'hC3; pkt[1] = 8'hFC; epkt[0] = 8'hC3; epkt[1] = 8'hFC;
        run_packet("R7 tail", 2, 1'b0, 1'b0, 2, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        test_reset();
        test_ignore_unmarked();
        test_handshake();
        test_data_crc16();
        test_zero_length_fixed();
        test_token_crc5();
        test_stuffing();
        test_tail_stuff();
        repeat (10) @(negedge clk);
        summary();
    end
endmodule